// File: doc/BRIEF.md
# Cascadable Latched Magnitude Comparator

This block decides the ordering of two 8-bit words, P and Q, and drives two flags: one high when P is above Q, the other when P is below Q. A mode pin picks unsigned ordering or two's-complement ordering. The P operand passes through a holding stage. While the load enable is high, P flows straight through to the comparison. While the enable is low, the last value seen is kept. Reset clears the held value to zero. Q is never held.

Two cascade inputs bring in the verdict of a less significant stage. When the local words are equal, that verdict passes straight through. When they differ, the local verdict wins. Chaining stages in this way compares words of any multiple of 8 bits with no extra logic. In a chain, only the top stage runs in signed mode, and the bottom stage's cascade inputs are tied low. A fully equal word then leaves both flags low.

Top module: `mag_cmp_stage`

## Requirements
- R1: With `signed_mode` = 0, the words are ordered as unsigned integers. `gt_out` = 1 and `lt_out` = 0 when P > Q, and `gt_out` = 0 and `lt_out` = 1 when P < Q.
- R2: With `signed_mode` = 1, the words are ordered as two's-complement integers, with bit 7 as the sign. For example, 8'h80 is below 8'h7F and 8'hFF is below 8'h01.
- R3: When the effective P differs from Q, exactly one of `gt_out` and `lt_out` is high, whatever the cascade inputs are.
- R4: When the effective P equals Q, `gt_out` equals `casc_gt_in` and `lt_out` equals `casc_lt_in`, in the same cycle.
- R5: While `p_load` is high, the effective P is `p_word` in the same cycle, and the held value is updated at each rising clock edge.
- R6: While `p_load` is low, the held P keeps its value, and changes on `p_word` have no effect on the outputs.
- R7: An active-low `rst_n` clears the held P to zero asynchronously.
- R8: Q is not held. A change on `q_word` reaches the outputs in the same cycle, whatever the level of `p_load`.
- R9: Three stages form a 24-bit comparator when each stage's outputs drive the next stage's cascade inputs, only the top stage is in signed mode, and the bottom stage's cascade inputs are low. Under those conditions the chain's flags match a 24-bit comparison in both modes, and both flags are low when the words are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the P holding register |
| rst_n | input | 1 | Asynchronous active-low reset; clears held P |
| p_load | input | 1 | 1: P transparent; 0: P held |
| p_word | input | WIDTH | P operand |
| q_word | input | WIDTH | Q operand (not held) |
| signed_mode | input | 1 | 0 unsigned, 1 two's complement |
| casc_gt_in | input | 1 | Greater verdict from the less significant stage |
| casc_lt_in | input | 1 | Less verdict from the less significant stage |
| gt_out | output | 1 | P above Q (or pass-through on equality) |
| lt_out | output | 1 | P below Q (or pass-through on equality) |

## Verification
The hardest case to reach from the ports is a comparison in which the held P differs from the value on `p_word`. Getting there means loading P, dropping the load enable between clock edges, and then moving `p_word` and `q_word` separately while the outputs are watched. The bench also drives the bottom stage's cascade inputs high on a fully equal 24-bit word. This shows that a verdict passes through all three stages. A table of 24-bit operand pairs puts the sign boundary in the top byte, the middle byte and the bottom byte.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    CMP_UNSIGNED = 1'b0,
    CMP_SIGNED   = 1'b1
  } cmp_mode_e;

  // Map a word onto an unsigned key whose natural ordering matches the
  // chosen interpretation: inverting the sign bit moves negatives below.
  function automatic logic [15:0] order_key(input logic [15:0] w,
                                             input int unsigned msb,
                                             input cmp_mode_e mode);
    logic [15:0] k;
    k = w;
    if (mode == CMP_SIGNED) k[msb] = ~w[msb];
    return k;
  endfunction
endpackage

// File: rtl/p_hold_latch.sv
module p_hold_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] held_q,
  output logic [WIDTH-1:0] eff_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_q <= '0;
    else if (load) held_q <= d_in;
  end

  // Transparent while loading, else the stored word
  assign eff_q = load ? d_in : held_q;

  // R5
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> held_q == $past(d_in));
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q));
  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> held_q == '0);
endmodule

// File: rtl/word_order.sv
module word_order
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmp_mode_e        mode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             loc_gt,
  output logic             loc_lt,
  output logic             loc_eq
);
  localparam int MSB = WIDTH - 1;
  logic [15:0] key_a, key_b;

  always_comb begin
    key_a = order_key(16'(a), MSB, mode);
    key_b = order_key(16'(b), MSB, mode);
  end

  assign loc_gt = key_a > key_b;
  assign loc_lt = key_a < key_b;
  assign loc_eq = ~(loc_gt | loc_lt);

  // R1
  unsigned_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMP_UNSIGNED && a[MSB] && !b[MSB]) |-> loc_gt);
  // R2
  signed_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CMP_SIGNED && a[MSB] && !b[MSB]) |-> loc_lt);
  // R4
  equal_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a == b) |-> loc_eq);
endmodule

// File: rtl/cascade_merge.sv
module cascade_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_gt,
  input  logic loc_lt,
  input  logic loc_eq,
  input  logic cin_gt,
  input  logic cin_lt,
  output logic out_gt,
  output logic out_lt
);
  assign out_gt = loc_eq ? cin_gt : loc_gt;
  assign out_lt = loc_eq ? cin_lt : loc_lt;

  // R3
  local_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_eq |-> ($countones({out_gt, out_lt}) == 1 && out_gt == loc_gt));
  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_eq |-> (out_gt == cin_gt && out_lt == cin_lt));
endmodule

// File: rtl/mag_cmp_stage.sv
module mag_cmp_stage
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             p_load,
  input  logic [WIDTH-1:0] p_word,
  input  logic [WIDTH-1:0] q_word,
  input  logic             signed_mode,
  input  logic             casc_gt_in,
  input  logic             casc_lt_in,
  output logic             gt_out,
  output logic             lt_out
);
  logic [WIDTH-1:0] p_held, p_eff;
  logic             loc_gt, loc_lt, loc_eq;
  cmp_mode_e        mode;

  assign mode = cmp_mode_e'(signed_mode);

  p_hold_latch #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(p_load), .d_in(p_word),
    .held_q(p_held), .eff_q(p_eff)
  );

  word_order #(.WIDTH(WIDTH)) u_order (
    .clk(clk), .rst_n(rst_n), .mode(mode), .a(p_eff), .b(q_word),
    .loc_gt(loc_gt), .loc_lt(loc_lt), .loc_eq(loc_eq)
  );

  cascade_merge u_merge (
    .clk(clk), .rst_n(rst_n), .loc_gt(loc_gt), .loc_lt(loc_lt),
    .loc_eq(loc_eq), .cin_gt(casc_gt_in), .cin_lt(casc_lt_in),
    .out_gt(gt_out), .out_lt(lt_out)
  );

  // R8
  q_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_load && p_held == q_word) |-> (gt_out == casc_gt_in && lt_out == casc_lt_in));
endmodule

// File: tb/mag_cmp_stage_tb_top.sv
`timescale 1ns/1ps
module mag_cmp_stage_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_load = 1'b0;
  logic [23:0] p24 = '0, q24 = '0;
  logic top_signed = 1'b0;
  logic cin_gt = 1'b0, cin_lt = 1'b0;
  logic g0, l0, g1, l1, gt, lt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mag_cmp_stage #(.WIDTH(8)) s0_i (
    .clk(clk), .rst_n(rst_n), .p_load(p_load), .p_word(p24[7:0]),
    .q_word(q24[7:0]), .signed_mode(1'b0), .casc_gt_in(cin_gt),
    .casc_lt_in(cin_lt), .gt_out(g0), .lt_out(l0));
  mag_cmp_stage #(.WIDTH(8)) s1_i (
    .clk(clk), .rst_n(rst_n), .p_load(p_load), .p_word(p24[15:8]),
    .q_word(q24[15:8]), .signed_mode(1'b0), .casc_gt_in(g0),
    .casc_lt_in(l0), .gt_out(g1), .lt_out(l1));
  mag_cmp_stage #(.WIDTH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .p_load(p_load), .p_word(p24[23:16]),
    .q_word(q24[23:16]), .signed_mode(top_signed), .casc_gt_in(g1),
    .casc_lt_in(l1), .gt_out(gt), .lt_out(lt));

  typedef struct packed {
    logic [23:0] p;
    logic [23:0] q;
    logic        sgn;
    logic        egt;
    logic        elt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 24'h000000, 1'b0, 1'b0, 1'b0},
    '{24'h123456, 24'h123455, 1'b0, 1'b1, 1'b0},
    '{24'h120000, 24'h130000, 1'b0, 1'b0, 1'b1},
    '{24'h800000, 24'h7FFFFF, 1'b0, 1'b1, 1'b0},
    '{24'h800000, 24'h7FFFFF, 1'b1, 1'b0, 1'b1},
    '{24'hFFFFFF, 24'h000001, 1'b1, 1'b0, 1'b1},
    '{24'hFFFFFF, 24'hFFFFFE, 1'b1, 1'b1, 1'b0},
    '{24'h00FF00, 24'h0100FF, 1'b0, 1'b0, 1'b1},
    '{24'h7F0000, 24'h80FFFF, 1'b1, 1'b1, 1'b0},
    '{24'hABCDEF, 24'hABCDEF, 1'b1, 1'b0, 1'b0},
    '{24'h0000FF, 24'h000100, 1'b0, 1'b0, 1'b1},
    '{24'hFF0001, 24'hFE00FF, 1'b1, 1'b1, 1'b0}
  };

  task automatic expect_flags(input string req, input logic eg, input logic el);
    checks++;
    if (gt !== eg || lt !== el) begin
      errors++;
      $display("FAIL %s: gt/lt actual %b%b expected %b%b (p=%h q=%h)",
               req, gt, lt, eg, el, p24, q24);
    end
  endtask

  initial begin : watchdog
    #400000ns;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset with load low; held P = 0, Q = 0, cascade low
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    expect_flags("R7", 1'b0, 1'b0);
    q24 = 24'h000001; #1;
    expect_flags("R7", 1'b0, 1'b1);
    rst_n = 1'b1;

    // R9, R1, R2: vector table through the 24-bit chain
    p_load = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      p24 = VECS[i].p; q24 = VECS[i].q; top_signed = VECS[i].sgn;
      #1;
      expect_flags(VECS[i].sgn ? "R9/R2" : "R9/R1", VECS[i].egt, VECS[i].elt);
    end

    // R3: local difference overrides asserted cascade inputs
    @(negedge clk);
    top_signed = 1'b0; p24 = 24'h000002; q24 = 24'h000001; cin_lt = 1'b1; #1;
    expect_flags("R3", 1'b1, 1'b0);
    // R4: equal words pass the bottom cascade verdict through all stages
    p24 = 24'h5A5A5A; q24 = 24'h5A5A5A; cin_lt = 1'b0; cin_gt = 1'b1; #1;
    expect_flags("R4", 1'b1, 1'b0);
    cin_gt = 1'b0; cin_lt = 1'b1; #1;
    expect_flags("R4", 1'b0, 1'b1);
    cin_lt = 1'b0; #1;
    expect_flags("R4", 1'b0, 1'b0);

    // R6: load 0x000010, drop load, then move P
    @(negedge clk);
    p24 = 24'h000010; q24 = 24'h000010;
    @(negedge clk);
    p_load = 1'b0;
    @(negedge clk);
    p24 = 24'hFFFFFF; #1;
    expect_flags("R6", 1'b0, 1'b0);
    @(negedge clk); #1;
    expect_flags("R6", 1'b0, 1'b0);
    // R8: Q acts at once while P is held
    q24 = 24'h000011; #1;
    expect_flags("R8", 1'b0, 1'b1);
    q24 = 24'h00000F; #1;
    expect_flags("R8", 1'b1, 1'b0);
    // R5: raising load exposes p_word in the same cycle
    q24 = 24'h000011; p_load = 1'b1; #1;
    expect_flags("R5", 1'b1, 1'b0);
    @(negedge clk);
    p_load = 1'b0; p24 = 24'h000000; #1;
    expect_flags("R5", 1'b1, 1'b0);

    // R7: mid-run reset clears the held word
    rst_n = 1'b0; q24 = 24'h000000; #1;
    expect_flags("R7", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    expect_flags("R7", 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule